// File: doc/BRIEF.md
# Trap and Status Register Controller

This block owns the processor status word, the exception return address, the last trap cause and the trap vector. It decides, one event per cycle, whether the core enters a trap, accepts an external interrupt or returns from an exception. For each of these it produces a registered redirect PC together with a pulse that says what happened. The pipeline drives synchronous trap requests with a cause code, eight level-sensitive interrupt lines, the PC of the instruction in flight and a return strobe. It reads and writes the control registers through a simple indexed port.

On trap or interrupt entry, the privilege bit and the interrupt-enable bit are each saved into a one-deep "previous" copy. The core then runs in supervisor mode with interrupts off. A return restores both bits from their saved copies and clears the saved copies. Interrupt lines are sampled into the pending field of the status word. The lowest-numbered line that is both pending and enabled in the mask is accepted.

Top module: `trap_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x0000_0001 (supervisor set, all else clear), and redirect_valid, trap_taken, irq_taken, illegal and tlb_flush are 0.
- R2: Status layout is: bit0 supervisor, bit1 previous supervisor, bit2 interrupt enable, bit3 previous enable, bit4 FPU enable, bit5 user 64-bit, bit6 supervisor 64-bit, bit7 VM enable, bit8 vector enable, bits 23:16 interrupt mask, bits 31:24 pending. Undefined bits read 0. Bits 4 and 8 read 0 when the FPU or vector unit is not configured. The pending field ignores writes and shows irq_pend as sampled one cycle earlier.
- R3: A trap request is acted on at the next clock edge. At that edge supervisor becomes 1, previous supervisor takes the old supervisor bit, previous enable takes the old enable bit, and enable becomes 0. EPC takes cur_pc and the cause register takes trap_cause. redirect_pc shows the vector register with redirect_valid high, and trap_taken pulses for one cycle with taken_cause equal to the cause.
- R4: A return strobe in supervisor mode sets supervisor from previous supervisor and enable from previous enable, clears both previous bits, and redirects to EPC.
- R5: A return strobe in user mode raises illegal for one cycle and produces no redirect. The status register is left unchanged.
- R6: An interrupt is accepted only when enable is 1 and pending AND mask is nonzero. The lowest such line index wins. The cause is 16 plus the line index. Status, EPC and redirect are updated as in R3, and irq_taken pulses instead of trap_taken.
- R7: A trap request takes priority over a return strobe and over an interrupt in the same cycle. A control-register write in a cycle with any trap, interrupt or return event is ignored.
- R8: ASID (index 6) reads 0, implementation (13) reads 1, hart ID (12) reads the HART_ID parameter, and the two IPI indices (10, 11) and undefined indices read 0. Writes to these indices have no effect.
- R9: A read of index 7 returns HART_ID and pulses tlb_flush for exactly one cycle, in the cycle the read data appears.
- R10: EPC (1), bad address (2), vector (3), cause (4, only CAUSE_W bits kept), page-table base (5), compare (9) and scratch (14, 15) return the last value written. Read data appears in the cycle after cr_re.
- R11: The count register (8) increments every cycle. A write loads it, so a read in the next cycle returns the written value and each later cycle adds one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_req | input | 1 | Synchronous trap request |
| trap_cause | input | CAUSE_W | Cause code for trap_req |
| irq_pend | input | 8 | Level interrupt lines |
| cur_pc | input | DATA_W | PC of the instruction in flight |
| eret | input | 1 | Return-from-exception strobe |
| cr_we | input | 1 | Control register write enable |
| cr_re | input | 1 | Control register read enable |
| cr_idx | input | 5 | Control register index |
| cr_wdata | input | DATA_W | Control register write data |
| cr_rdata | output | DATA_W | Control register read data, one cycle after cr_re |
| redirect_valid | output | 1 | Redirect PC is valid this cycle |
| redirect_pc | output | DATA_W | Target PC for trap, interrupt or return |
| trap_taken | output | 1 | Trap entered |
| irq_taken | output | 1 | Interrupt entered |
| taken_cause | output | CAUSE_W | Cause of the trap or interrupt just entered |
| illegal | output | 1 | Return attempted outside supervisor mode |
| tlb_flush | output | 1 | Flush pulse from a read of index 7 |

## Verification
The assertions assume that trap_req, eret, cr_we and cr_re are single-cycle strobes and that each is cleared as soon as the event it requests has been seen. They also assume cr_idx is stable while cr_re is high. The bench drives every strobe for exactly one cycle on the falling edge and then returns it to 0. It holds irq_pend steady across the two cycles an interrupt needs to be sampled and accepted. It waits for an interrupt-taking sequence to finish before it rewrites the status word.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int STATUS_W = 32;
  localparam int NIRQ     = 8;
  localparam int IDX_W    = 5;

  localparam int B_SUP    = 0;
  localparam int B_PSUP   = 1;
  localparam int B_IEN    = 2;
  localparam int B_PIEN   = 3;
  localparam int B_FPU    = 4;
  localparam int B_U64    = 5;
  localparam int B_S64    = 6;
  localparam int B_VM     = 7;
  localparam int B_VEC    = 8;
  localparam int MASK_LO  = 16;
  localparam int PEND_LO  = 24;

  typedef enum logic [IDX_W-1:0] {
    CR_STATUS  = 5'd0,
    CR_EPC     = 5'd1,
    CR_BADADDR = 5'd2,
    CR_VECTOR  = 5'd3,
    CR_CAUSE   = 5'd4,
    CR_PTBASE  = 5'd5,
    CR_ASID    = 5'd6,
    CR_FLUSH   = 5'd7,
    CR_COUNT   = 5'd8,
    CR_CMP     = 5'd9,
    CR_IPI_SET = 5'd10,
    CR_IPI_CLR = 5'd11,
    CR_HART    = 5'd12,
    CR_IMPL    = 5'd13,
    CR_SCR0    = 5'd14,
    CR_SCR1    = 5'd15
  } cr_idx_e;

  localparam int BANK_SLOTS = 5;
  localparam int BANK_AW    = $clog2(BANK_SLOTS);

  // {hit, slot} for the plain storage registers held in the bank
  function automatic logic [BANK_AW:0] bank_slot(input logic [IDX_W-1:0] idx);
    case (idx)
      CR_BADADDR: bank_slot = {1'b1, BANK_AW'(0)};
      CR_PTBASE:  bank_slot = {1'b1, BANK_AW'(1)};
      CR_CMP:     bank_slot = {1'b1, BANK_AW'(2)};
      CR_SCR0:    bank_slot = {1'b1, BANK_AW'(3)};
      CR_SCR1:    bank_slot = {1'b1, BANK_AW'(4)};
      default:    bank_slot = '0;
    endcase
  endfunction
endpackage

// File: rtl/trap_irq_pick.sv
module trap_irq_pick #(
  parameter  int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    // R6: a reported winner is always a requesting line
    assert_pick_valid_R6: assert (!any || req[idx]);
  end
endmodule

// File: rtl/trap_reg_bank.sv
module trap_reg_bank #(
  parameter  int DW    = 32,
  parameter  int SLOTS = 5,
  localparam int AW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [SLOTS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/trap_status_ctrl.sv
module trap_status_ctrl
  import trap_pkg::*;
#(
  parameter int DATA_W         = 32,
  parameter int CAUSE_W        = 5,
  parameter int IRQ_CAUSE_BASE = 16,
  parameter int HART_ID        = 0,
  parameter bit HAS_FPU        = 1'b0,
  parameter bit HAS_VEC        = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trap_req,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [NIRQ-1:0]    irq_pend,
  input  logic [DATA_W-1:0]  cur_pc,
  input  logic               eret,
  input  logic               cr_we,
  input  logic               cr_re,
  input  logic [IDX_W-1:0]   cr_idx,
  input  logic [DATA_W-1:0]  cr_wdata,
  output logic [DATA_W-1:0]  cr_rdata,
  output logic               redirect_valid,
  output logic [DATA_W-1:0]  redirect_pc,
  output logic               trap_taken,
  output logic               irq_taken,
  output logic [CAUSE_W-1:0] taken_cause,
  output logic               illegal,
  output logic               tlb_flush
);
  localparam int IRQ_IW = $clog2(NIRQ);

  // status fields
  logic sup_q, psup_q, ien_q, pien_q, fpu_q, u64_q, s64_q, vm_q, vec_q;
  logic [NIRQ-1:0] mask_q, pend_q;
  logic [STATUS_W-1:0] status_word;

  logic [DATA_W-1:0]  epc_q, vec_base_q, count_q;
  logic [CAUSE_W-1:0] cause_q;

  assign status_word = {pend_q, mask_q, 7'b0, vec_q, vm_q, s64_q, u64_q,
                        fpu_q, pien_q, ien_q, psup_q, sup_q};

  // interrupt selection
  logic              irq_any;
  logic [IRQ_IW-1:0] irq_idx;

  trap_irq_pick #(.N(NIRQ)) u_pick (
    .req (pend_q & mask_q),
    .any (irq_any),
    .idx (irq_idx)
  );

  // event priority: trap, then return, then interrupt
  logic take_trap, do_ret, ret_ok, ret_bad, take_irq, enter, wr_ok;
  logic [CAUSE_W-1:0] enter_cause;

  always_comb begin
    take_trap   = trap_req;
    do_ret      = !trap_req && eret;
    ret_ok      = do_ret && sup_q;
    ret_bad     = do_ret && !sup_q;
    take_irq    = !trap_req && !eret && ien_q && irq_any;
    enter       = take_trap || take_irq;
    wr_ok       = cr_we && !trap_req && !eret && !take_irq;
    enter_cause = take_trap ? trap_cause
                            : CAUSE_W'(IRQ_CAUSE_BASE) + CAUSE_W'(irq_idx);
  end

  // status, EPC, cause, vector and event outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      sup_q <= 1'b1; psup_q <= 1'b0; ien_q <= 1'b0; pien_q <= 1'b0;
      fpu_q <= 1'b0; u64_q <= 1'b0; s64_q <= 1'b0; vm_q <= 1'b0; vec_q <= 1'b0;
      mask_q <= '0; pend_q <= '0;
      epc_q <= '0; vec_base_q <= '0; cause_q <= '0;
      redirect_valid <= 1'b0; redirect_pc <= '0;
      trap_taken <= 1'b0; irq_taken <= 1'b0; taken_cause <= '0;
      illegal <= 1'b0;
    end else begin
      pend_q         <= irq_pend;
      redirect_valid <= 1'b0;
      trap_taken     <= 1'b0;
      irq_taken      <= 1'b0;
      illegal        <= 1'b0;
      if (enter) begin
        sup_q          <= 1'b1;
        psup_q         <= sup_q;
        ien_q          <= 1'b0;
        pien_q         <= ien_q;
        epc_q          <= cur_pc;
        cause_q        <= enter_cause;
        redirect_valid <= 1'b1;
        redirect_pc    <= vec_base_q;
        trap_taken     <= take_trap;
        irq_taken      <= take_irq;
        taken_cause    <= enter_cause;
      end else if (ret_ok) begin
        sup_q          <= psup_q;
        psup_q         <= 1'b0;
        ien_q          <= pien_q;
        pien_q         <= 1'b0;
        redirect_valid <= 1'b1;
        redirect_pc    <= epc_q;
      end else if (ret_bad) begin
        illegal        <= 1'b1;
      end else if (wr_ok) begin
        case (cr_idx)
          CR_STATUS: begin
            sup_q  <= cr_wdata[B_SUP];
            psup_q <= cr_wdata[B_PSUP];
            ien_q  <= cr_wdata[B_IEN];
            pien_q <= cr_wdata[B_PIEN];
            fpu_q  <= HAS_FPU && cr_wdata[B_FPU];
            u64_q  <= cr_wdata[B_U64];
            s64_q  <= cr_wdata[B_S64];
            vm_q   <= cr_wdata[B_VM];
            vec_q  <= HAS_VEC && cr_wdata[B_VEC];
            mask_q <= cr_wdata[MASK_LO +: NIRQ];
          end
          CR_EPC:    epc_q      <= cr_wdata;
          CR_VECTOR: vec_base_q <= cr_wdata;
          CR_CAUSE:  cause_q    <= cr_wdata[CAUSE_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // free-running count
  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else if (wr_ok && cr_idx == CR_COUNT) count_q <= cr_wdata;
    else count_q <= count_q + 1'b1;
  end

  // plain storage registers in a RAM-style bank
  logic [BANK_AW:0] wslot, rslot;
  logic [DATA_W-1:0] bank_rdata;
  assign wslot = bank_slot(cr_idx);
  assign rslot = bank_slot(cr_idx);

  trap_reg_bank #(.DW(DATA_W), .SLOTS(BANK_SLOTS)) u_bank (
    .clk   (clk),
    .we    (wr_ok && wslot[BANK_AW]),
    .waddr (wslot[BANK_AW-1:0]),
    .wdata (cr_wdata),
    .re    (cr_re && rslot[BANK_AW]),
    .raddr (rslot[BANK_AW-1:0]),
    .rdata (bank_rdata)
  );

  // read path for everything outside the bank
  logic [DATA_W-1:0] fix_rdata_q;
  logic              from_bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_rdata_q <= '0;
      from_bank_q <= 1'b0;
      tlb_flush   <= 1'b0;
    end else begin
      tlb_flush <= cr_re && (cr_idx == CR_FLUSH);
      if (cr_re) begin
        from_bank_q <= rslot[BANK_AW];
        case (cr_idx)
          CR_STATUS:         fix_rdata_q <= DATA_W'(status_word);
          CR_EPC:            fix_rdata_q <= epc_q;
          CR_VECTOR:         fix_rdata_q <= vec_base_q;
          CR_CAUSE:          fix_rdata_q <= DATA_W'(cause_q);
          CR_COUNT:          fix_rdata_q <= count_q;
          CR_FLUSH, CR_HART: fix_rdata_q <= DATA_W'(HART_ID);
          CR_IMPL:           fix_rdata_q <= DATA_W'(1);
          default:           fix_rdata_q <= '0;
        endcase
      end
    end
  end

  assign cr_rdata = from_bank_q ? bank_rdata : fix_rdata_q;

  // R3: entry leaves the core in supervisor mode with interrupts off
  assert_trap_enter_R3: assert property (@(posedge clk) disable iff (rst)
    (trap_taken || irq_taken) |-> (sup_q && !ien_q && redirect_valid));

  // R6: an interrupt is only accepted with enable set the cycle before
  assert_irq_enable_R6: assert property (@(posedge clk) disable iff (rst)
    irq_taken |-> $past(ien_q));

  // R7: at most one event is reported per cycle
  assert_one_event_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trap_taken, irq_taken, illegal}));

  // R5: a refused return changes neither privilege nor control flow
  assert_ret_user_R5: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!redirect_valid && !sup_q && !$past(sup_q)));

  // R9: flush pulses only in answer to a read of the flush index
  assert_flush_src_R9: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> $past(cr_re && cr_idx == CR_FLUSH));
endmodule

// File: tb/trap_status_ctrl_tb.sv
`timescale 1ns/100ps
module trap_status_ctrl_tb;
  localparam int DW   = 32;
  localparam int CW   = 5;
  localparam int HART = 5;
  localparam int NV   = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trap_req = 1'b0;
  logic [CW-1:0] trap_cause = '0;
  logic [7:0]    irq_pend = '0;
  logic [DW-1:0] cur_pc = '0;
  logic          eret = 1'b0;
  logic          cr_we = 1'b0;
  logic          cr_re = 1'b0;
  logic [4:0]    cr_idx = '0;
  logic [DW-1:0] cr_wdata = '0;
  logic [DW-1:0] cr_rdata;
  logic          redirect_valid;
  logic [DW-1:0] redirect_pc;
  logic          trap_taken, irq_taken, illegal, tlb_flush;
  logic [CW-1:0] taken_cause;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  trap_status_ctrl #(.DATA_W(DW), .CAUSE_W(CW), .HART_ID(HART)) u_dut (
    .clk(clk), .rst(rst), .trap_req(trap_req), .trap_cause(trap_cause),
    .irq_pend(irq_pend), .cur_pc(cur_pc), .eret(eret), .cr_we(cr_we),
    .cr_re(cr_re), .cr_idx(cr_idx), .cr_wdata(cr_wdata), .cr_rdata(cr_rdata),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .trap_taken(trap_taken), .irq_taken(irq_taken), .taken_cause(taken_cause),
    .illegal(illegal), .tlb_flush(tlb_flush)
  );

  // {index, write data, expected read}
  localparam logic [68:0] VEC [NV] = '{
    {5'd1,  32'h0000_1000, 32'h0000_1000},
    {5'd2,  32'hCAFE_0002, 32'hCAFE_0002},
    {5'd3,  32'h0000_0200, 32'h0000_0200},
    {5'd4,  32'hFFFF_FFFF, 32'h0000_001F},
    {5'd5,  32'h8000_0000, 32'h8000_0000},
    {5'd6,  32'h0000_1234, 32'h0000_0000},
    {5'd9,  32'h0000_0055, 32'h0000_0055},
    {5'd10, 32'h0000_00FF, 32'h0000_0000},
    {5'd11, 32'h0000_00FF, 32'h0000_0000},
    {5'd12, 32'h0000_0099, 32'h0000_0005},
    {5'd13, 32'h0000_0077, 32'h0000_0001},
    {5'd14, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {5'd15, 32'h5A5A_5A5A, 32'h5A5A_5A5A},
    {5'd20, 32'h0000_FFFF, 32'h0000_0000},
    {5'd0,  32'hFFFF_FFFF, 32'h00FF_00EF}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic cr_write(input logic [4:0] idx, input logic [DW-1:0] d);
    cr_we = 1'b1; cr_idx = idx; cr_wdata = d;
    @(negedge clk);
    cr_we = 1'b0;
  endtask

  task automatic cr_read(input logic [4:0] idx, output logic [DW-1:0] d);
    cr_re = 1'b1; cr_idx = idx;
    @(negedge clk);
    cr_re = 1'b0;
    d = cr_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] rd;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 redirect_valid", DW'(redirect_valid), 0);
    chk("R1 pulses", DW'({trap_taken, irq_taken, illegal, tlb_flush}), 0);
    cr_read(5'd0, rd); chk("R1 status", rd, 32'h0000_0001);

    // R2 R8 R10 table of writes and read-backs
    for (int i = 0; i < NV; i++) begin
      logic [4:0] vi; logic [31:0] vw, ve;
      {vi, vw, ve} = VEC[i];
      cr_write(vi, vw);
      cr_read(vi, rd);
      if (vi == 5'd0) chk("R2 status write mask", rd, ve);
      else if (vi == 5'd6 || vi >= 5'd10 && vi <= 5'd13 || vi == 5'd20)
        chk("R8 constant index", rd, ve);
      else chk("R10 storage read-back", rd, ve);
    end

    // R3 trap entry from supervisor with enable set
    cr_write(5'd0, 32'h00FF_0005);
    trap_req = 1'b1; trap_cause = 5'd3; cur_pc = 32'h1234;
    @(negedge clk);
    trap_req = 1'b0;
    chk("R3 trap_taken", DW'(trap_taken), 1);
    chk("R3 redirect_valid", DW'(redirect_valid), 1);
    chk("R3 redirect_pc", redirect_pc, 32'h200);
    chk("R3 taken_cause", DW'(taken_cause), 3);
    @(negedge clk);
    chk("R3 trap pulse ends", DW'(trap_taken), 0);
    cr_read(5'd0, rd); chk("R3 status push", rd, 32'h00FF_000B);
    cr_read(5'd1, rd); chk("R3 epc", rd, 32'h1234);
    cr_read(5'd4, rd); chk("R3 cause", rd, 3);

    // R4 return pops both bits
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
    chk("R4 redirect_valid", DW'(redirect_valid), 1);
    chk("R4 redirect_pc", redirect_pc, 32'h1234);
    cr_read(5'd0, rd); chk("R4 status pop", rd, 32'h00FF_0005);

    // R3 R4 from user mode, then R5 refused return
    cr_write(5'd0, 32'h00FF_0004);
    trap_req = 1'b1; trap_cause = 5'd8; cur_pc = 32'h40;
    @(negedge clk);
    trap_req = 1'b0;
    cr_read(5'd0, rd); chk("R3 status from user", rd, 32'h00FF_0009);
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
    cr_read(5'd0, rd); chk("R4 back to user", rd, 32'h00FF_0004);
    eret = 1'b1;
    @(negedge clk);
    eret = 1'b0;
    chk("R5 illegal", DW'(illegal), 1);
    chk("R5 no redirect", DW'(redirect_valid), 0);
    cr_read(5'd0, rd); chk("R5 status kept", rd, 32'h00FF_0004);

    // R6 lowest pending line wins
    irq_pend = 8'h28; cur_pc = 32'h300;
    @(negedge clk);
    chk("R6 not yet sampled", DW'(irq_taken), 0);
    @(negedge clk);
    chk("R6 irq_taken", DW'(irq_taken), 1);
    chk("R6 cause line 3", DW'(taken_cause), 19);
    chk("R6 redirect_pc", redirect_pc, 32'h200);
    irq_pend = 8'h00;
    idle(2);
    cr_read(5'd0, rd); chk("R6 status push", rd, 32'h00FF_0009);
    cr_read(5'd1, rd); chk("R6 epc", rd, 32'h300);

    // R6 mask leaves only line 5
    cr_write(5'd0, 32'h0020_0005);
    irq_pend = 8'h28;
    @(negedge clk);
    @(negedge clk);
    chk("R6 masked pick", DW'(irq_taken), 1);
    chk("R6 masked cause", DW'(taken_cause), 21);
    irq_pend = 8'h00;
    idle(2);

    // R6 enable clear blocks, R2 pending field reflects lines
    cr_write(5'd0, 32'h00FF_0001);
    irq_pend = 8'hFF;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 disabled no irq", DW'(irq_taken), 0);
    end
    cr_read(5'd0, rd); chk("R2 pending field", rd, 32'hFFFF_0001);
    cr_write(5'd0, 32'h00FF_0001);
    cr_read(5'd0, rd); chk("R2 pending ignores write", rd, 32'hFFFF_0001);
    irq_pend = 8'h00;
    idle(2);

    // R7 trap beats return and a concurrent write
    trap_req = 1'b1; trap_cause = 5'd2; cur_pc = 32'h88; eret = 1'b1;
    cr_we = 1'b1; cr_idx = 5'd14; cr_wdata = 32'h0000_DEAD;
    @(negedge clk);
    trap_req = 1'b0; eret = 1'b0; cr_we = 1'b0;
    chk("R7 trap wins", DW'(trap_taken), 1);
    chk("R7 no illegal", DW'(illegal), 0);
    chk("R7 redirect to vector", redirect_pc, 32'h200);
    chk("R7 cause", DW'(taken_cause), 2);
    cr_read(5'd14, rd); chk("R7 write dropped", rd, 32'hA5A5_A5A5);
    cr_read(5'd0, rd); chk("R7 status", rd, 32'h00FF_0003);

    // R9 flush read
    cr_read(5'd7, rd);
    chk("R9 flush pulse", DW'(tlb_flush), 1);
    chk("R9 flush data", rd, HART);
    @(negedge clk);
    chk("R9 flush ends", DW'(tlb_flush), 0);

    // R11 count
    cr_write(5'd8, 32'd1000);
    cr_re = 1'b1; cr_idx = 5'd8;
    @(negedge clk);
    chk("R11 count loaded", cr_rdata, 32'd1000);
    @(negedge clk);
    cr_re = 1'b0;
    chk("R11 count increments", cr_rdata, 32'd1001);

    finish_run();
  end
endmodule